// File: doc/BRIEF.md
# Serial Addressed Gain-Control Register Bank

This block holds the gain settings for eight audio gain stages and takes new settings over a slow three-wire serial link. The link has a serial clock, a data line and a load strobe. Each 8-bit command carries three fields. The most significant bit is an enable. The next three bits pick a channel. The low four bits give that channel's gain code. Bits move into a shift register on every rising edge of the serial clock. A command acts only when the strobe produces its execute edge, and then only the addressed channel changes.

The strobe comes in two polarities, and either one can drive the block. The active-high strobe pin idles high and executes on a falling edge. The inverted strobe pin idles low and executes on a rising edge. A pin that is left at its idle level never executes anything. Gain code zero does not select a gain step. It marks its channel as muted and powered down, and a separate flag reports when all eight channels are muted.

All serial pins are sampled by a much faster system clock through two-flop synchronizers, and edges are detected in that clock domain. The system clock must run fast enough that every serial clock and strobe level lasts several system cycles.

Top module: `gctl_serial_bank`

## Requirements
- R1: After a synchronous reset, every channel code is 0000, every mute flag is 1, the all-muted flag is 1, and the shift register holds zero.
- R2: On each rising edge of the serial clock, the data bit is shifted in at the LSB end. A command is sent bit 7 first and bit 0 last.
- R3: A command with bit 7 = 1 writes its code (bits 3..0) into the channel whose index is bits 6..4. Index 0..7 maps to `gain_codes_o[4*k +: 4]`. No other channel changes.
- R4: A command with bit 7 = 0 changes no channel when it is executed.
- R5: Active-high strobe: a falling edge executes the command. A rising edge does nothing, and shifting with the pin held low changes no output.
- R6: Inverted strobe: a rising edge executes the command, and a falling edge does nothing.
- R7: With the active-high strobe held high and the inverted strobe held low, no channel ever changes.
- R8: `mute_o[k]` is 1 exactly when channel k holds code 0000.
- R9: `all_mute_o` is 1 exactly when all eight codes were 0000 one system clock earlier.
- R10: A channel code changes on the third system-clock rising edge after the strobe pin changes level. That is two synchronizer stages plus the register.
- R11: An execute edge decodes the last 8 bits shifted in. Any extra earlier bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock; data shifts on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| strobe_hi_i | input | 1 | Active-high load strobe; idles high, executes on fall |
| strobe_lo_i | input | 1 | Inverted load strobe; idles low, executes on rise |
| gain_codes_o | output | 32 | Eight 4-bit channel codes, channel k at bits 4k+3..4k |
| mute_o | output | 8 | Per-channel mute/powersave flag |
| all_mute_o | output | 1 | High when every channel is muted |

## Verification
The properties assume that the serial pins move slowly compared with the system clock. Each serial clock, data and strobe level must stay stable for several system cycles, so that the synchronized data bit is settled when the synchronized serial clock rises. The bench enforces this. It changes data only while the serial clock is low, and it holds each level three to four cycles before the next change. It also moves only one strobe pin at a time. Every strobe transition, including entering or leaving a mode, is treated as a possible execute edge and is modelled as one.

// File: rtl/gctl_pkg.sv
package gctl_pkg;

    localparam int unsigned NUM_CH = 8;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned SEL_W  = $clog2(NUM_CH);
    localparam int unsigned WORD_W = 1 + SEL_W + CODE_W;

    // Idle (pulled) levels of the serial pins, used as synchronizer reset values
    localparam logic IDLE_SCLK = 1'b1;
    localparam logic IDLE_HI   = 1'b1;
    localparam logic IDLE_LO   = 1'b0;

    typedef struct packed {
        logic                  enable;
        logic [SEL_W-1:0]      sel;
        logic [CODE_W-1:0]     code;
    } word_t;

    typedef struct packed {
        logic shift;
        logic exec;
    } evt_t;

    function automatic logic code_is_mute(input logic [CODE_W-1:0] c);
        return (c == '0);
    endfunction

endpackage

// File: rtl/gctl_sync.sv
module gctl_sync #(
    parameter int unsigned     W       = 1,
    parameter int unsigned     STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stg[s] <= RST_VAL;
                    else       stg[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stg[s] <= RST_VAL;
                    else       stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/gctl_edge.sv
module gctl_edge
    import gctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic sclk_s_i,
    input  logic hi_s_i,
    input  logic lo_s_i,
    output evt_t evt_o
);

    logic sclk_d, hi_d, lo_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sclk_d <= IDLE_SCLK;
            hi_d   <= IDLE_HI;
            lo_d   <= IDLE_LO;
        end else begin
            sclk_d <= sclk_s_i;
            hi_d   <= hi_s_i;
            lo_d   <= lo_s_i;
        end
    end

    always_comb begin
        evt_o.shift = sclk_s_i & ~sclk_d;
        // falling edge of the active-high pin or rising edge of the inverted pin
        evt_o.exec  = (hi_d & ~hi_s_i) | (~lo_d & lo_s_i);
    end

endmodule

// File: rtl/gctl_shift.sv
module gctl_shift #(
    parameter int unsigned WORD_W = gctl_pkg::WORD_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] sh_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)        sh_q <= '0;
        else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], bit_i};
    end

    assign word_o = sh_q;

endmodule

// File: rtl/gctl_bank.sv
module gctl_bank
    import gctl_pkg::*;
#(
    parameter int unsigned N_CH = NUM_CH,
    parameter int unsigned CW   = CODE_W
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               exec_i,
    input  word_t              word_i,
    output logic [N_CH*CW-1:0] codes_o,
    output logic [N_CH-1:0]    mute_o,
    output logic               all_mute_o
);

    logic [CW-1:0] code_q [N_CH];

    generate
        for (genvar k = 0; k < N_CH; k++) begin : g_ch
            logic hit;
            assign hit = exec_i & word_i.enable & (word_i.sel == SEL_W'(k));

            always_ff @(posedge clk_i) begin
                if (rst_i)    code_q[k] <= '0;
                else if (hit) code_q[k] <= word_i.code;
            end

            assign codes_o[k*CW +: CW] = code_q[k];
            assign mute_o[k]           = code_is_mute(code_q[k]);
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) all_mute_o <= 1'b1;
        else       all_mute_o <= &mute_o;
    end

endmodule

// File: rtl/gctl_serial_bank.sv
module gctl_serial_bank
    import gctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       sclk_i,
    input  logic                       sdata_i,
    input  logic                       strobe_hi_i,
    input  logic                       strobe_lo_i,
    output logic [NUM_CH*CODE_W-1:0]   gain_codes_o,
    output logic [NUM_CH-1:0]          mute_o,
    output logic                       all_mute_o
);

    localparam int unsigned PINS = 4;
    localparam logic [PINS-1:0] PIN_IDLE = {IDLE_SCLK, 1'b0, IDLE_HI, IDLE_LO};

    logic [PINS-1:0]   pins_s;
    logic              sclk_s, data_s, hi_s, lo_s;
    evt_t              evt;
    logic              shift_pulse, exec_pulse;
    logic [WORD_W-1:0] sh_word;

    gctl_sync #(
        .W       (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({sclk_i, sdata_i, strobe_hi_i, strobe_lo_i}),
        .q_o   (pins_s)
    );

    assign {sclk_s, data_s, hi_s, lo_s} = pins_s;

    gctl_edge u_edge (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .sclk_s_i (sclk_s),
        .hi_s_i   (hi_s),
        .lo_s_i   (lo_s),
        .evt_o    (evt)
    );

    assign shift_pulse = evt.shift;
    assign exec_pulse  = evt.exec;

    gctl_shift #(.WORD_W(WORD_W)) u_shift (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .shift_i (shift_pulse),
        .bit_i   (data_s),
        .word_o  (sh_word)
    );

    gctl_bank #(.N_CH(NUM_CH), .CW(CODE_W)) u_bank (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .exec_i     (exec_pulse),
        .word_i     (word_t'(sh_word)),
        .codes_o    (gain_codes_o),
        .mute_o     (mute_o),
        .all_mute_o (all_mute_o)
    );

endmodule

// File: rtl/gctl_serial_bank_chk.sv
module gctl_serial_bank_chk #(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 4
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic [NUM_CH*CODE_W-1:0] codes_i,
    input  logic                     all_mute_i,
    input  logic                     exec_i,
    input  logic                     shift_i,
    input  logic                     data_s_i,
    input  logic                     word_msb_i,
    input  logic                     word_lsb_i
);

    logic [NUM_CH*CODE_W-1:0] codes_past;
    logic [NUM_CH-1:0]        chg;

    always_ff @(posedge clk_i) begin
        if (rst_i) codes_past <= '0;
        else       codes_past <= codes_i;
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_chg
            assign chg[k] = codes_i[k*CODE_W +: CODE_W] != codes_past[k*CODE_W +: CODE_W];
        end
    endgenerate

    p_shift_capture_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        shift_i |=> (word_lsb_i == $past(data_s_i)));

    p_one_channel_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(chg) <= 1);

    p_disabled_word_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (exec_i && !word_msb_i) |=> $stable(codes_i));

    p_only_on_exec_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        !exec_i |=> $stable(codes_i));

    p_allmute_lag_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> (all_mute_i == ($past(codes_i) == '0)));

endmodule

bind gctl_serial_bank gctl_serial_bank_chk #(
    .NUM_CH (gctl_pkg::NUM_CH),
    .CODE_W (gctl_pkg::CODE_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .codes_i    (gain_codes_o),
    .all_mute_i (all_mute_o),
    .exec_i     (exec_pulse),
    .shift_i    (shift_pulse),
    .data_s_i   (data_s),
    .word_msb_i (sh_word[gctl_pkg::WORD_W-1]),
    .word_lsb_i (sh_word[0])
);

// File: tb/gctl_serial_bank_bench.sv
module gctl_serial_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        sdata = 1'b0;
    logic        strobe_hi = 1'b1;
    logic        strobe_lo = 1'b0;
    logic [31:0] codes;
    logic [7:0]  mute;
    logic        all_mute;

    always #2 clk = ~clk;   // 250 MHz

    gctl_serial_bank u_gctl_serial_bank (
        .clk_i        (clk),
        .rst_i        (rst),
        .sclk_i       (sclk),
        .sdata_i      (sdata),
        .strobe_hi_i  (strobe_hi),
        .strobe_lo_i  (strobe_lo),
        .gain_codes_o (codes),
        .mute_o       (mute),
        .all_mute_o   (all_mute)
    );

    int    total = 0;
    int    bad   = 0;
    int    cyc   = 0;
    bit    mon_en = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    logic [3:0] exp_code [8];
    logic       exp_all = 1'b1;
    bit         sh_q [$];

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (mon_en && !done) begin
            for (int k = 0; k < 8; k++) begin
                total++;
                if (codes[k*4 +: 4] !== exp_code[k]) begin
                    bad++;
                    $display("FAIL %s R3 R10 ch%0d code got %h exp %h", cur_req, k, codes[k*4 +: 4], exp_code[k]);
                end
                total++;
                if (mute[k] !== (exp_code[k] == 4'd0)) begin
                    bad++;
                    $display("FAIL %s R8 ch%0d mute got %b exp %b", cur_req, k, mute[k], exp_code[k] == 4'd0);
                end
            end
            total++;
            if (all_mute !== exp_all) begin
                bad++;
                $display("FAIL %s R9 all_mute got %b exp %b", cur_req, all_mute, exp_all);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired got %0d cycles exp < 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        @(negedge clk);
        sdata = b;
        tick(3);
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
        sh_q.push_back(b);
        tick(3);
    endtask

    task automatic send_word(input logic [7:0] w);
        for (int i = 7; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic model_exec();
        logic [7:0] w;
        for (int i = 0; i < 8; i++) w[7-i] = sh_q[sh_q.size()-8+i];
        if (w[7]) exp_code[w[6:4]] = w[3:0];
    endtask

    // pin edge was driven at the preceding negedge: codes move on the third
    // rising edge, the all-muted flag one edge later
    task automatic exec_wait();
        bit z;
        @(posedge clk);
        @(posedge clk);
        @(posedge clk);
        model_exec();
        @(posedge clk);
        z = 1'b1;
        for (int k = 0; k < 8; k++) if (exp_code[k] != 4'd0) z = 1'b0;
        exp_all = z;
        tick(2);
    endtask

    task automatic hi_fall();  @(negedge clk); strobe_hi = 1'b0; exec_wait(); endtask
    task automatic hi_rise();  @(negedge clk); strobe_hi = 1'b1; tick(8);     endtask
    task automatic lo_rise();  @(negedge clk); strobe_lo = 1'b1; exec_wait(); endtask
    task automatic lo_fall();  @(negedge clk); strobe_lo = 1'b0; tick(8);     endtask
    task automatic pulse_hi(); hi_rise(); hi_fall(); endtask
    task automatic pulse_lo(); lo_fall(); lo_rise(); endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_code[k] = 4'd0;
        for (int i = 0; i < 8; i++) sh_q.push_back(1'b0);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        mon_en = 1'b1;

        // R1 reset state, R7 idle pins do nothing
        cur_req = "R1";
        tick(20);
        cur_req = "R7";
        tick(40);

        // enter active-high mode: the fall executes the cleared word (ignored)
        cur_req = "R5";
        hi_fall();

        // R2 / R3 single write, R10 latency watched every cycle
        cur_req = "R10";
        send_word(8'h9A);
        pulse_hi();

        // R3 every channel gets its own code
        cur_req = "R3";
        for (int k = 0; k < 8; k++) begin
            send_word({1'b1, 3'(k), 4'(k + 4)});
            pulse_hi();
        end

        // R4 disabled command
        cur_req = "R4";
        send_word(8'h35);
        pulse_hi();
        send_word(8'h70);
        pulse_hi();

        // R11 extra leading bits pushed out
        cur_req = "R11";
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_word(8'hC7);
        pulse_hi();

        // R2 bit order: asymmetric pattern
        cur_req = "R2";
        send_word(8'hB1);
        pulse_hi();

        // R5 shifting with strobe low has no effect, rise does nothing
        cur_req = "R5";
        send_word(8'hF3);
        tick(40);
        hi_rise();
        tick(20);

        // R6 inverted mode: rise executes pending word, fall does nothing
        cur_req = "R6";
        lo_rise();
        send_word(8'h85);
        lo_fall();
        tick(20);
        lo_rise();
        send_word(8'hAE);
        pulse_lo();

        // R8 / R9 mute every channel
        cur_req = "R9";
        for (int k = 0; k < 8; k++) begin
            send_word({1'b1, 3'(k), 4'd0});
            pulse_lo();
        end
        cur_req = "R8";
        send_word(8'hD9);
        pulse_lo();
        send_word(8'hD0);
        pulse_lo();

        // R7 back to idle levels
        cur_req = "R7";
        lo_fall();
        send_word(8'hFF);
        tick(60);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule